// File: doc/BRIEF.md
# Parallel Self-Clocked LED Line Encoder

This block turns per-lane colour byte streams into the pulse-width waveforms that single-wire, self-clocked LED strings expect. It drives up to eight lanes at once. One shared bit timer paces every lane, so all lanes rise on the same clock and finish each bit slot together. Each slot has three parts. All enabled lanes go high for a first stretch. Each lane then holds its own bit value for a second stretch. All lanes are then low for a final stretch. A lane carrying a 1 therefore shows a long high pulse, and a lane carrying a 0 shows a short one.

Bytes arrive over a valid/ready stream. Each beat carries one byte for every lane, with lane `l` in bits `8l+7:8l`. A frame is three bytes per pixel per lane. The block holds the beat in a one-deep holding register and transposes it into a slot-by-slot bit matrix. It sends the most significant bit first. The next beat is taken while the current byte is shifting out, so slots follow each other with no gap. A beat transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the holding register is empty and no latch gap is running, and that includes the idle state, so the first beat of a frame can be preloaded before `start`. The source may hold `in_valid` low as long as it likes. However, if the holding register is still empty at a byte boundary inside a frame, the frame is aborted rather than stretched.

After the last slot, or after an abort, the lines stay low for a latch gap of `LATCH_US` microseconds at `CLK_MHZ`. `busy` stays high until this gap ends, and `start` is acted on only when `busy` is low.

Top module: `par_led_encoder`

## Requirements
- R1: A bit slot lasts exactly T_RISE+T_BIT+T_TAIL clocks, and within a frame the next slot begins on the clock right after the previous one ends.
- R2: During the first T_RISE clocks of a slot, every lane below LANES is high.
- R3: During the next T_BIT clocks, each lane below LANES equals its current data bit.
- R4: During the last T_TAIL clocks of a slot, all lanes are low.
- R5: `lane_out` bits at index LANES and above are always low.
- R6: The byte for lane `l` is taken from `in_data[8l+7:8l]`, and its bits go out most significant bit first, one per slot, over 8 slots.
- R7: A beat transfers when `in_valid` and `in_ready` are both high. `in_ready` is low while the holding register is full or during a latch gap. A frame carries 3*NPIX beats.
- R8: After the last slot of a frame, all lanes stay low and `busy` stays high for exactly LATCH_US*CLK_MHZ clocks, after which `busy` falls.
- R9: `start` is ignored while `busy` is high: it neither begins a frame nor lengthens the latch gap.
- R10: If a byte is needed (at `start` or at a byte boundary) and the holding register is empty, all lanes go low from the next clock, `underrun` is set and a latch gap follows. `underrun` is cleared by the next frame that starts with data present.
- R11: Synchronous reset drives all lanes low and clears `busy`, `underrun` and the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a frame (acted on only while idle) |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Byte beat accepted at this edge when valid |
| in_data | input | 8*LANES | One byte per lane, lane l at bits 8l+7:8l |
| lane_out | output | 8 | Line waveforms, one bit per lane |
| busy | output | 1 | Frame or latch gap in progress |
| underrun | output | 1 | Last frame was aborted for lack of data |

## Verification
The encoder is tested with four frame patterns. The first uses a distinct byte on each lane, so a swapped lane or a wrong bit order shows up in a single slot. The second uses all-ones and all-zeros lanes beside alternating bits, which separates the high-pulse stretch from the data stretch and the tail. The third is a frame fed only two of its six beats, which checks the abort at a byte boundary and the gap that follows. The fourth is a start with no data at all. A start pulse placed inside a latch gap shows whether a request that should be ignored lengthens the gap or begins a new frame.

// File: rtl/led_wave_pkg.sv
package led_wave_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } wave_st_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int T_RISE = 2,
  parameter int T_BIT  = 3,
  parameter int T_TAIL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic hi_ph,
  output logic dat_ph,
  output logic slot_last
);
  localparam int TOTAL = T_RISE + T_BIT + T_TAIL;
  localparam int CW = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] P_RISE = CW'(T_RISE);
  localparam logic [CW-1:0] P_DATA = CW'(T_RISE + T_BIT);
  localparam logic [CW-1:0] P_LAST = CW'(TOTAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)          cnt <= '0;
    else if (cnt == P_LAST)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign hi_ph     = en && (cnt < P_RISE);
  assign dat_ph    = en && (cnt < P_DATA);
  assign slot_last = en && (cnt == P_LAST);

  // a new slot must open with its rising phase (R1, R2)
  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (slot_last) |=> (!en || hi_ph));
  // the tail phase never overlaps the rising phase (R4)
  assert_tail_low_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !dat_ph) |-> !hi_ph);
endmodule

// File: rtl/bit_transpose.sv
module bit_transpose #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] bytes_in,
  output logic [8*LANES-1:0] slots_out
);
  // slot s, lane l <- bit (7-s) of lane l's byte
  for (genvar s = 0; s < 8; s++) begin : g_slot
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign slots_out[s*LANES + l] = bytes_in[l*8 + 7 - s];
    end
  end
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int GAP = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int GW = $clog2(GAP + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GAP - 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == G_LAST);

  assert_gap_once_R8: assert property (@(posedge clk) disable iff (rst)
    (done && en) |=> !done);
endmodule

// File: rtl/par_led_encoder.sv
module par_led_encoder #(
  parameter int LANES    = 4,
  parameter int T_RISE   = 2,
  parameter int T_BIT    = 3,
  parameter int T_TAIL   = 3,
  parameter int NPIX     = 2,
  parameter int LATCH_US = 50,
  parameter int CLK_MHZ  = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*LANES-1:0] in_data,
  output logic [7:0]         lane_out,
  output logic               busy,
  output logic               underrun
);
  import led_wave_pkg::*;

  localparam int FRAME = 3 * NPIX;
  localparam int LW    = $clog2(FRAME + 1);
  localparam int GAP   = LATCH_US * CLK_MHZ;

  wave_st_e            st;
  logic [8*LANES-1:0]  nxt_byte;
  logic                nxt_full;
  logic [8*LANES-1:0]  cur;
  logic [8*LANES-1:0]  tmat;
  logic [2:0]          bit_idx;
  logic [LW-1:0]       left;
  logic                hi_ph, dat_ph, slot_last, gap_done;
  logic                acc, need_byte, load, starve;

  slot_timer #(.T_RISE(T_RISE), .T_BIT(T_BIT), .T_TAIL(T_TAIL)) u_timer (
    .clk(clk), .rst(rst), .en(st == ST_RUN),
    .hi_ph(hi_ph), .dat_ph(dat_ph), .slot_last(slot_last)
  );

  bit_transpose #(.LANES(LANES)) u_xpose (
    .bytes_in(nxt_byte), .slots_out(tmat)
  );

  gap_timer #(.GAP(GAP)) u_gap (
    .clk(clk), .rst(rst), .en(st == ST_GAP), .done(gap_done)
  );

  assign in_ready  = !nxt_full && (st != ST_GAP);
  assign acc       = in_valid && in_ready;
  assign need_byte = ((st == ST_IDLE) && start) ||
                     ((st == ST_RUN) && slot_last && (bit_idx == 3'd7) && (left != '0));
  assign load      = need_byte && nxt_full;
  assign starve    = need_byte && !nxt_full;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      nxt_full <= 1'b0;
      nxt_byte <= '0;
      cur      <= '0;
      bit_idx  <= '0;
      left     <= '0;
      underrun <= 1'b0;
    end else begin
      if (load)     nxt_full <= 1'b0;
      else if (acc) nxt_full <= 1'b1;
      if (acc)      nxt_byte <= in_data;

      unique case (st)
        ST_IDLE: if (start) begin
          underrun <= starve;
          if (load) begin
            st      <= ST_RUN;
            cur     <= tmat;
            bit_idx <= '0;
            left    <= LW'(FRAME - 1);
          end else begin
            st <= ST_GAP;
          end
        end
        ST_RUN: if (slot_last) begin
          if (bit_idx != 3'd7) begin
            bit_idx <= bit_idx + 1'b1;
            cur     <= cur >> LANES;
          end else if (left == '0) begin
            st <= ST_GAP;
          end else if (load) begin
            cur     <= tmat;
            bit_idx <= '0;
            left    <= left - 1'b1;
          end else begin
            st       <= ST_GAP;
            underrun <= 1'b1;
          end
        end
        ST_GAP: if (gap_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar l = 0; l < 8; l++) begin : g_out
    if (l < LANES) begin : g_on
      assign lane_out[l] = hi_ph || (dat_ph && cur[l]);
    end else begin : g_off
      assign lane_out[l] = 1'b0;
    end
  end

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy) |-> (lane_out == 8'h00));
  assert_upper_low_R5: assert property (@(posedge clk) disable iff (rst)
    (32'(lane_out) >> LANES) == 32'd0);
  assert_abort_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> (busy && lane_out == 8'h00));
  assert_gap_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (start && st == ST_GAP && !gap_done) |=> (st == ST_GAP));
  assert_gap_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(lane_out) == 8'h00));
endmodule

// File: tb/sim_par_led_encoder.sv
module sim_par_led_encoder;
  localparam int CLK_PER = 10;
  localparam int LANES = 4, T1 = 2, T2 = 3, T3 = 3, NPIX = 2;
  localparam int TOT = T1 + T2 + T3;
  localparam int GAP = 20;
  localparam logic [7:0] MASK = 8'h0F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [8*LANES-1:0] in_data = '0;
  logic [7:0] lane_out;
  logic busy, underrun;

  always #(CLK_PER/2) clk = ~clk;

  par_led_encoder #(.LANES(LANES), .T_RISE(T1), .T_BIT(T2), .T_TAIL(T3),
    .NPIX(NPIX), .LATCH_US(GAP), .CLK_MHZ(1)) u0 (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lane_out(lane_out), .busy(busy), .underrun(underrun));

  logic [31:0] feed_q[$];
  logic [7:0]  exp_q[$];
  bit exp_under = 1'b0;
  bit mon_done = 1'b0;
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // feeder: presents queued beats on the valid/ready stream
  initial begin
    forever begin
      @(negedge clk);
      in_valid = (feed_q.size() > 0);
      in_data  = in_valid ? feed_q[0] : '0;
      if (!rst && in_valid && in_ready) void'(feed_q.pop_front());
    end
  end

  // monitor: pops one expected slot per TOT cycles and compares
  logic [7:0] e, bad_hi, bad_d, bad_lo;
  bit ok_hi, ok_d, ok_lo, ok_up, ok_gap;
  int ngap;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && exp_q.size() > 0 && lane_out != 8'h00) begin
        while (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          ok_hi = 1; ok_d = 1; ok_lo = 1; ok_up = 1;
          bad_hi = MASK; bad_d = e; bad_lo = 0;
          for (int c = 0; c < TOT; c++) begin
            if (c > 0) @(negedge clk);
            if (lane_out[7:LANES] != 0) ok_up = 0;
            if (c < T1) begin
              if (lane_out != MASK) begin ok_hi = 0; bad_hi = lane_out; end
            end else if (c < T1 + T2) begin
              if (lane_out != e) begin ok_d = 0; bad_d = lane_out; end
            end else if (lane_out != 8'h00) begin
              ok_lo = 0; bad_lo = lane_out;
            end
          end
          chk(ok_hi, "R2 rise phase", 32'(bad_hi), 32'(MASK));
          chk(ok_d, "R3 R6 data phase", 32'(bad_d), 32'(e));
          chk(ok_lo, "R4 R1 tail phase", 32'(bad_lo), 32'h0);
          chk(ok_up, "R5 upper lanes", 32'(lane_out), 32'h0);
          if (exp_q.size() > 0) @(negedge clk);
        end
        ngap = 0; ok_gap = 1;
        @(negedge clk);
        while (busy && ngap < 500) begin
          if (lane_out != 8'h00) ok_gap = 0;
          ngap++;
          @(negedge clk);
        end
        chk(ok_gap, "R8 lines low in gap", 32'(lane_out), 32'h0);
        chk(ngap == GAP, "R8 gap length", 32'(ngap), 32'(GAP));
        chk(underrun == exp_under, "R10 underrun flag", 32'(underrun), 32'(exp_under));
        mon_done = 1'b1;
      end
    end
  end

  // driver: queues beats and the expected slot vectors, then starts
  task automatic run_frame(input logic [31:0] bt [6], input int nsend, input bit und);
    for (int i = 0; i < nsend; i++) begin
      feed_q.push_back(bt[i]);
      for (int b = 0; b < 8; b++) begin
        logic [7:0] v;
        v = 8'h00;
        for (int l = 0; l < LANES; l++) v[l] = bt[i][l*8 + 7 - b];
        exp_q.push_back(v);
      end
    end
    exp_under = und;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R7 ready low when holding full", 32'(in_ready), 32'h0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !underrun, "R10 flag clear after good start", {busy, underrun}, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic [31:0] fa [6];
    logic [31:0] fb [6];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(lane_out == 0 && !busy && !underrun, "R11 reset state", {lane_out, busy, underrun}, 32'h0);
    chk(in_ready == 1'b1, "R7 ready when empty", 32'(in_ready), 32'h1);

    // A: distinct byte per lane
    fa = '{32'h01F03CA5, 32'h8000FF5A, 32'h7E1281C3, 32'h55AA0F69, 32'hC0030990, 32'h1248B6DB};
    run_frame(fa, 6, 1'b0);
    wait (exp_q.size() == 0);
    repeat (TOT + 4) @(negedge clk);
    chk(in_ready == 1'b0 && busy, "R7 ready low in gap", {in_ready, busy}, 32'h1);
    start = 1'b1;              // R9: must be ignored
    @(negedge clk);
    start = 1'b0;
    wait (mon_done); mon_done = 1'b0;
    begin
      bit q;
      q = 1;
      repeat (6) begin
        @(negedge clk);
        if (busy || lane_out != 0) q = 0;
      end
      chk(q, "R9 start in gap ignored", {busy, lane_out}, 32'h0);
    end

    // B: solid ones, solid zeros, alternating
    fb = '{32'hAA00FFFF, 32'h55FF0000, 32'h0F0FF0F0, 32'hFFAA5500, 32'h00CC33FF, 32'h80010180};
    run_frame(fb, 6, 1'b0);
    wait (mon_done); mon_done = 1'b0;

    // C: starved after two beats
    run_frame(fa, 2, 1'b1);
    wait (mon_done); mon_done = 1'b0;

    // D: good frame after abort clears the flag
    run_frame(fb, 6, 1'b0);
    wait (mon_done); mon_done = 1'b0;

    // E: start with nothing queued
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && underrun && lane_out == 0, "R10 empty start aborts", {lane_out, busy, underrun}, 32'h3);
    begin
      int n;
      n = 1;
      @(negedge clk);
      while (busy && n < 500) begin n++; @(negedge clk); end
      chk(n == GAP, "R8 gap after empty start", 32'(n), 32'(GAP));
    end
    summary();
  end
endmodule